// File: doc/BRIEF.md
# Parallel Converter Read Sequencer

This block is a synchronous master that runs one complete conversion-and-read transaction on an external successive-approximation converter. The converter has a chip-enable strobe, an active-low select, a read/convert select, and a byte-address line. A one-cycle start request latches two mode choices. The first picks a full 12-bit or a short 8-bit conversion. The second picks one 12-bit word read or two byte reads over an 8-bit path. The block then raises a convert strobe, waits for the converter's STATUS line to drop, reads the result, and presents it with a one-cycle valid pulse.

The converter's timing limits are given in nanoseconds: select setup, strobe width, status delay, data access and bus float. Each limit is a parameter, and the block rounds it up to whole clock periods using a clock-period parameter. The strobe is held in the pin state that applies at each point of the sequence. In byte mode the converter puts left-justified bytes on its upper eight data lines. The block rebuilds the word from the high byte and from the upper nibble of the low byte. If STATUS stays high longer than a configured maximum, the transaction is abandoned and an error pulse is raised.

Top module: `adc_rd_seq`

## Requirements
- R1: After reset and whenever no transaction is active, `ce_o` is 0, `cs_n_o` is 1, `valid_o` is 0, `err_o` is 0 and `busy_o` is 0.
- R2: Convert strobe: `cs_n_o` is low and `rc_o` is 0 for at least N_SU = ceil(T_SU_NS/CLK_NS) cycles before `ce_o` rises. `ce_o` stays high at least N_CE cycles. `ao_o` during the strobe is 1 for an 8-bit conversion and 0 for a 12-bit conversion.
- R3: `busy_i` is ignored for N_STS cycles after the convert strobe falls. After that window the block waits until `busy_i` is 0 before reading.
- R4: Each read strobe has `rc_o` = 1 and `cs_n_o` low for at least N_SU cycles before `ce_o` rises. `ce_o` is held for N_ACC cycles, and `db_i` is captured in the last of them. `rc_o` and `ao_o` do not change while `ce_o` is high.
- R5: Word mode (`byte_rd_i` = 0): exactly one read strobe, with `wide_o` = 1 and `ao_o` = 0. `result_o` equals `db_i[11:0]`.
- R6: Byte mode (`byte_rd_i` = 1): exactly two read strobes, with `wide_o` = 0, `ao_o` = 0 on the first and 1 on the second. `result_o[11:4]` = first `db_i[11:4]` and `result_o[3:0]` = second `db_i[11:8]`.
- R7: After each read strobe falls, `cs_n_o` stays high and `ce_o` low for at least N_FLT cycles before the next select or the valid pulse.
- R8: A completed transaction gives exactly one one-cycle `valid_o` pulse with the result on `result_o`.
- R9: If `busy_i` is still 1 after N_TMO cycles of waiting (the waiting starts once the R3 window ends), `err_o` pulses for one cycle. The transaction then ends with no read strobe and no `valid_o`.
- R10: `start_i` while `busy_o` is 1 is ignored: no second conversion is started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled in idle |
| short_conv_i | input | 1 | 1 = 8-bit conversion, 0 = 12-bit |
| byte_rd_i | input | 1 | 1 = two byte reads, 0 = one word read |
| busy_i | input | 1 | Converter STATUS, high while converting |
| db_i | input | 12 | Converter data lines |
| ce_o | output | 1 | Chip-enable strobe to converter |
| cs_n_o | output | 1 | Active-low chip select |
| rc_o | output | 1 | 1 = read, 0 = convert |
| ao_o | output | 1 | Conversion length / byte address |
| wide_o | output | 1 | 1 = all 12 data lines enabled |
| result_o | output | 12 | Assembled result |
| valid_o | output | 1 | One-cycle result valid pulse |
| err_o | output | 1 | One-cycle STATUS timeout pulse |
| busy_o | output | 1 | Transaction in progress |

## Verification
The bench builds the block with a 10 ns clock and the default interval limits, which gives setup 5, strobe 5, status window 20, access 15 and float 10 cycles. The conversion maximum is lowered to 1000 ns (100 cycles), so a stuck STATUS reaches the timeout in a short run. A converter model raises STATUS late inside the status window and drives valid data only a cycle before the access window closes. With that model, sampling early or reading too soon both give wrong words. The bench sweeps sixteen codes spread over the full 12-bit range, in all four combinations of conversion length and read width.

// File: rtl/adc_rd_seq.sv
module adc_rd_seq #(
  parameter int CLK_NS        = 10,
  parameter int T_SU_NS       = 50,
  parameter int T_CE_NS       = 50,
  parameter int T_STS_NS      = 200,
  parameter int T_ACC_NS      = 150,
  parameter int T_FLT_NS      = 100,
  parameter int T_CONV_MAX_NS = 30000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        short_conv_i,
  input  logic        byte_rd_i,
  input  logic        busy_i,
  input  logic [11:0] db_i,
  output logic        ce_o,
  output logic        cs_n_o,
  output logic        rc_o,
  output logic        ao_o,
  output logic        wide_o,
  output logic [11:0] result_o,
  output logic        valid_o,
  output logic        err_o,
  output logic        busy_o
);
  function automatic int cyc(int ns);
    return (ns <= CLK_NS) ? 1 : (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_SU  = cyc(T_SU_NS);
  localparam int N_CE  = cyc(T_CE_NS);
  localparam int N_STS = cyc(T_STS_NS);
  localparam int N_ACC = cyc(T_ACC_NS);
  localparam int N_FLT = cyc(T_FLT_NS);
  localparam int N_TMO = cyc(T_CONV_MAX_NS);
  localparam int N_MAX = mx(mx(mx(N_SU, N_CE), mx(N_STS, N_ACC)), mx(N_FLT, N_TMO));
  localparam int CW    = $clog2(N_MAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SU_CV, S_CE_CV, S_STS_RISE, S_STS_FALL,
    S_SU_RD, S_CE_RD, S_FLT, S_DONE
  } st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic        short_q, byte_q, hi_q;
  logic [11:0] res_q;
  logic        err_q;
  logic        last;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      short_q <= 1'b0;
      byte_q  <= 1'b0;
      hi_q    <= 1'b0;
      res_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (!last) cnt <= cnt - 1'b1;
      case (st)
        S_IDLE: if (start_i) begin
          short_q <= short_conv_i;
          byte_q  <= byte_rd_i;
          hi_q    <= 1'b0;
          cnt     <= CW'(N_SU - 1);
          st      <= S_SU_CV;
        end
        S_SU_CV: if (last) begin
          cnt <= CW'(N_CE - 1);
          st  <= S_CE_CV;
        end
        S_CE_CV: if (last) begin
          cnt <= CW'(N_STS - 1);
          st  <= S_STS_RISE;
        end
        S_STS_RISE: if (last) begin
          cnt <= CW'(N_TMO - 1);
          st  <= S_STS_FALL;
        end
        S_STS_FALL: if (!busy_i) begin
          cnt <= CW'(N_SU - 1);
          st  <= S_SU_RD;
        end else if (last) begin
          err_q <= 1'b1;
          st    <= S_IDLE;
        end
        S_SU_RD: if (last) begin
          cnt <= CW'(N_ACC - 1);
          st  <= S_CE_RD;
        end
        S_CE_RD: if (last) begin
          if (!byte_q)    res_q       <= db_i;
          else if (!hi_q) res_q[11:4] <= db_i[11:4];
          else            res_q[3:0]  <= db_i[11:8];
          cnt <= CW'(N_FLT - 1);
          st  <= S_FLT;
        end
        S_FLT: if (last) begin
          if (byte_q && !hi_q) begin
            hi_q <= 1'b1;
            cnt  <= CW'(N_SU - 1);
            st   <= S_SU_RD;
          end else begin
            st <= S_DONE;
          end
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic in_cv, in_rd;
  assign in_cv    = (st == S_SU_CV) || (st == S_CE_CV);
  assign in_rd    = (st == S_SU_RD) || (st == S_CE_RD);
  assign ce_o     = (st == S_CE_CV) || (st == S_CE_RD);
  assign cs_n_o   = !(in_cv || in_rd);
  assign rc_o     = in_rd;
  assign ao_o     = in_cv ? short_q : (in_rd && byte_q && hi_q);
  assign wide_o   = !byte_q;
  assign result_o = res_q;
  assign valid_o  = (st == S_DONE);
  assign err_o    = err_q;
  assign busy_o   = (st != S_IDLE);
endmodule

module adc_rd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_o,
  input logic cs_n_o,
  input logic rc_o,
  input logic ao_o,
  input logic valid_o,
  input logic err_o,
  input logic busy_o
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!ce_o && cs_n_o && !valid_o));
  p_ce_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_o |-> !cs_n_o);
  p_ce_rise_after_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_o) |-> $past(!cs_n_o));
  p_pins_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_o && $past(ce_o)) |-> ($stable(rc_o) && $stable(ao_o)));
  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (!err_o && !busy_o));
  p_err_no_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !valid_o);
endmodule

bind adc_rd_seq adc_rd_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ce_o(ce_o), .cs_n_o(cs_n_o), .rc_o(rc_o),
  .ao_o(ao_o), .valid_o(valid_o), .err_o(err_o), .busy_o(busy_o)
);

// File: tb/adc_rd_seq_tb.sv
module adc_rd_seq_tb_top;
  localparam int PERIOD = 10;
  localparam int N_SU = 5, N_CE = 5, N_ACC = 15, N_FLT = 10;
  localparam int STS_DLY = 19;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, short_conv_i = 1'b0, byte_rd_i = 1'b0, busy_i = 1'b0;
  logic [11:0] db_i = 12'h5A5;
  logic ce_o, cs_n_o, rc_o, ao_o, wide_o, valid_o, err_o, busy_o;
  logic [11:0] result_o;

  adc_rd_seq #(.CLK_NS(PERIOD), .T_CONV_MAX_NS(1000)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .short_conv_i(short_conv_i),
    .byte_rd_i(byte_rd_i), .busy_i(busy_i), .db_i(db_i), .ce_o(ce_o),
    .cs_n_o(cs_n_o), .rc_o(rc_o), .ao_o(ao_o), .wide_o(wide_o),
    .result_o(result_o), .valid_o(valid_o), .err_o(err_o), .busy_o(busy_o));

  always #(PERIOD/2) clk = ~clk;

  int total = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model and monitor state
  logic [11:0] analog_v = '0, cv = '0;
  bit hang = 0, converting = 0, prev_ce = 0, cur_rd = 0, after_rd = 0;
  int conv_len = 20, conv_t = 0, rd_hi = 0, cs_lo = 0, ce_w = 0, gap = 0;
  int conv_cnt = 0, rd_cnt = 0, valid_cnt = 0, err_cnt = 0;
  bit conv_ao = 0, su_bad = 0, w_bad = 0, pin_bad = 0, flt_bad = 0;
  logic [11:0] res_seen = '0;

  initial forever begin
    @(negedge clk);
    if (ce_o && !prev_ce) begin
      cur_rd = rc_o;
      if (cs_lo < N_SU) su_bad = 1;
      if (!rc_o) begin
        conv_cnt++; conv_ao = ao_o;
        converting = 1; conv_t = 0;
        cv = short_conv_i ? (analog_v & 12'hFF0) : analog_v;
      end else begin
        if (wide_o !== !byte_rd_i) pin_bad = 1;
        if (ao_o !== (byte_rd_i && rd_cnt == 1)) pin_bad = 1;
        if (after_rd && gap < N_FLT + N_SU) flt_bad = 1;
        rd_cnt++;
      end
      ce_w = 0;
    end
    if (!ce_o && prev_ce) begin
      if (ce_w < (cur_rd ? N_ACC : N_CE)) w_bad = 1;
      if (cur_rd) begin after_rd = 1; gap = 0; end
    end
    if (ce_o) ce_w++;
    if (after_rd && !ce_o) begin
      if (gap < N_FLT && !cs_n_o) flt_bad = 1;
      if (valid_o && gap < N_FLT) flt_bad = 1;
      gap++;
    end
    cs_lo = (!cs_n_o && !ce_o) ? cs_lo + 1 : 0;
    prev_ce = ce_o;
    if (valid_o) begin valid_cnt++; res_seen = result_o; end
    if (err_o) err_cnt++;
    if (converting) begin
      conv_t++;
      busy_i = (conv_t >= STS_DLY) && (hang || conv_t < STS_DLY + conv_len);
      if (!hang && conv_t >= STS_DLY + conv_len) converting = 0;
    end else busy_i = 0;
    if (ce_o && !cs_n_o && rc_o) begin
      rd_hi++;
      if (rd_hi >= N_ACC - 1 && !busy_i)
        db_i = !byte_rd_i ? cv : (ao_o ? {cv[3:0], 8'h00} : {cv[11:4], 4'h0});
      else db_i = 12'h5A5;
    end else begin
      rd_hi = 0; db_i = 12'h5A5;
    end
  end

  task automatic run_one(logic [11:0] v, bit sh, bit by, bit hg, bit restart, int clen);
    logic [11:0] exp_v;
    analog_v = v; hang = hg; conv_len = clen;
    conv_cnt = 0; rd_cnt = 0; valid_cnt = 0; err_cnt = 0; after_rd = 0;
    su_bad = 0; w_bad = 0; pin_bad = 0; flt_bad = 0;
    @(negedge clk);
    short_conv_i = sh; byte_rd_i = by; start_i = 1;
    @(negedge clk);
    start_i = 0;
    if (restart) begin
      repeat (30) @(negedge clk);
      start_i = 1; short_conv_i = ~sh;
      @(negedge clk);
      start_i = 0; short_conv_i = sh;
    end
    for (int k = 0; k < 2000 && busy_o; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    hang = 0;
    exp_v = sh ? (v & 12'hFF0) : v;
    chk(conv_cnt == 1, "R10 one conversion", conv_cnt, 1);
    chk(conv_ao == sh, "R2 conversion length pin", conv_ao, sh);
    chk(!su_bad && !w_bad, "R2/R4 setup and strobe width", {su_bad, w_bad}, 0);
    chk(!busy_o && cs_n_o && !ce_o, "R1 idle after run", busy_o, 0);
    if (hg) begin
      chk(err_cnt == 1, "R9 timeout error pulse", err_cnt, 1);
      chk(rd_cnt == 0 && valid_cnt == 0, "R9 no read after timeout", rd_cnt + valid_cnt, 0);
    end else begin
      chk(err_cnt == 0, "R3 no error", err_cnt, 0);
      chk(rd_cnt == (by ? 2 : 1), by ? "R6 two reads" : "R5 one read", rd_cnt, by ? 2 : 1);
      chk(!pin_bad, by ? "R6 byte pins" : "R5 word pins", pin_bad, 0);
      chk(!flt_bad, "R7 float interval", flt_bad, 0);
      chk(valid_cnt == 1, "R8 one valid pulse", valid_cnt, 1);
      chk(res_seen == exp_v, by ? "R6 byte reassembly" : "R4 word capture", res_seen, exp_v);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!ce_o && cs_n_o && !valid_o && !err_o && !busy_o, "R1 reset state",
        {ce_o, cs_n_o, valid_o, err_o, busy_o}, 5'b01000);
    rst_n = 1;
    @(negedge clk);
    chk(!busy_o && !ce_o, "R1 idle after reset", busy_o, 0);
    for (int i = 0; i < 16; i++)
      for (int m = 0; m < 4; m++)
        run_one(12'(i * 273), m[0], m[1], 0, (i == 5), 20 + i);
    run_one(12'h9C3, 0, 1, 1, 0, 20);
    run_one(12'h3F7, 0, 0, 0, 0, 2);
    run_one(12'hFFF, 1, 1, 0, 1, 40);
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule